// File: doc/BRIEF.md
# Transparent Galloping-Pattern RAM Self-Test Controller

This controller runs a non-destructive coupling-fault test over a chosen address window of a single-port synchronous RAM. The RAM contents stay in service. No background pattern is written. For each cell under test in turn, the controller compresses every other cell of the window into a 16-bit CRC signature. It then complements the cell under test and compresses the others again, and the two signatures must agree. It then writes the original value back and compresses a third time, and that signature must also agree with the first. While the cell is complemented, the controller reads the cell back after each read of another cell. Each read-back must return the complemented value.

The signature is a CRC-16 with generator 0x1021, seeded with 0xFFFF at the start of every pass. A word is folded in most-significant byte first, one byte per clock. The RAM returns read data one cycle after the request.

A run starts with a one-cycle start pulse that carries the window bounds. The controller reports the end of the run with a one-cycle done pulse. Fail and the failing address stay valid until the next accepted start. When a mismatch is found, the controller still writes the original value back into the cell under test before it stops.

Top module: `tgp_ram_tester`

## Requirements
- R1: While reset is held and after reset is released, busy, done, fail and the RAM enable are all low.
- R2: At the end of every run, passing or failing, every RAM cell holds the value it held before the run.
- R3: During a run, every RAM access falls inside the window [lo, hi] that was latched when the run was accepted.
- R4: Each cell under test gets exactly two writes in a row. The first writes the bitwise complement of its original value. The second writes the original value to the same address.
- R5: A cell is never part of its own signature passes. In a window of N cells with no fault, each cell under test costs exactly 1 + 4(N-1) reads: one read of the cell itself, N-1 reads for the reference pass, N-1 pairs of (other cell, read-back of the cell under test) for the complemented pass, and N-1 reads for the restored pass.
- R6: If complementing the cell under test changes another cell, the signature comparison flags it. Fail rises with that cell's address, and no further cell is tested.
- R7: If a read-back of the complemented cell returns anything but the complement, fail is raised at once with that cell's address. The cell is restored and the run ends, with no further reads.
- R8: Done is high for exactly one cycle. Busy is high from the cycle after an accepted start until done. Fail and the failing address hold until the next accepted start, which clears them.
- R9: A start with lo greater than hi ends with done in the next cycle. It makes no RAM access and leaves fail low.
- R10: A window of one cell costs one read and two writes and passes.
- R11: A start pulse that arrives while a run is in progress is ignored. The bounds in force do not change.
- R12: Cells are tested in ascending address order, beginning at lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| lo_addr_i | input | AW | Lowest address of the window |
| hi_addr_i | input | AW | Highest address of the window |
| mem_en_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write (1) or read (0) |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after a read request |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | The last run found a fault (valid while not busy) |
| fail_addr_o | output | AW | Address of the cell under test when the fault was found |

## Verification
The hardest case to reach from the ports is a fault that appears only while a cell is complemented. A healthy RAM never produces one. The bench RAM model therefore carries two injectable defects, each set before a run. The first flips a neighbour bit whenever one chosen address is written, which changes the complemented-pass signature. The second pins one bit of a chosen cell, so only the read-back catches it. For both defects the bench works out the exact read and write counts up to the point where the controller stops. It also confirms that the defects leave the memory image intact afterwards.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CUT_RD,
    ST_CUT_WT,
    ST_PASS_CHK,
    ST_SIG_RD,
    ST_SIG_WT,
    ST_FOLD,
    ST_BK_RD,
    ST_BK_WT,
    ST_PASS_END,
    ST_INV_WR,
    ST_RESTORE,
    ST_FIN
  } tgp_state_e;

  typedef enum logic [1:0] {
    PASS_REF = 2'd0,
    PASS_INV = 2'd1,
    PASS_RST = 2'd2
  } tgp_pass_e;

  localparam logic [15:0] SIG_POLY = 16'h1021;
  localparam logic [15:0] SIG_SEED = 16'hFFFF;

  // Folds one byte into the running signature, most significant bit first.
  function automatic logic [15:0] sig_fold_byte(input logic [15:0] crc,
                                                input logic [7:0]  b);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ SIG_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/tgp_sig_unit.sv
module tgp_sig_unit
  import tgp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          fold_i,
  input  logic          save_i,
  output logic          last_o,
  output logic          match_o
);
  localparam int NB = DW / 8;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;

  logic [15:0]   sig_q, sig_d;
  logic [15:0]   ref_q, ref_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sig_d  = sig_q;
    ref_d  = ref_q;
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      sig_d = SIG_SEED;
    end else if (fold_i) begin
      sig_d = sig_fold_byte(sig_q, hold_q[DW-1 -: 8]);
    end
    if (load_i) begin
      hold_d = word_i;
      cnt_d  = '0;
    end else if (fold_i) begin
      hold_d = hold_q << 8;
      cnt_d  = cnt_q + CW'(1);
    end
    if (save_i) ref_d = sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= SIG_SEED;
      ref_q  <= SIG_SEED;
      hold_q <= '0;
      cnt_q  <= '0;
    end else begin
      sig_q  <= sig_d;
      ref_q  <= ref_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign last_o  = (cnt_q == CW'(NB - 1));
  assign match_o = (sig_q == ref_q);

  // R6
  sig_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sig_q == SIG_SEED));

endmodule

// File: rtl/tgp_addr_walk.sv
module tgp_addr_walk #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          cut_next_i,
  input  logic          oth_first_i,
  input  logic          oth_next_i,
  output logic [AW-1:0] cut_o,
  output logic [AW-1:0] oth_o,
  output logic          cut_last_o,
  output logic          oth_more_o,
  output logic          bad_o
);
  localparam int XW = AW + 1;

  logic [AW-1:0] lo_q, hi_q, cut_q;
  logic [AW-1:0] lo_d, hi_d, cut_d;
  logic [XW-1:0] oth_q, oth_d;
  logic          bad_q, bad_d;
  logic [XW-1:0] oth_first_v, oth_inc, oth_step;

  always_comb begin
    oth_first_v = (lo_q == cut_q) ? ({1'b0, lo_q} + XW'(1)) : {1'b0, lo_q};
    oth_inc     = oth_q + XW'(1);
    oth_step    = (oth_inc == {1'b0, cut_q}) ? (oth_q + XW'(2)) : oth_inc;
  end

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    cut_d = cut_q;
    oth_d = oth_q;
    bad_d = bad_q;
    if (start_i) begin
      lo_d  = lo_i;
      hi_d  = hi_i;
      cut_d = lo_i;
      bad_d = (lo_i > hi_i);
      oth_d = '1;
    end else begin
      if (cut_next_i)  cut_d = cut_q + AW'(1);
      if (oth_first_i) oth_d = oth_first_v;
      else if (oth_next_i) oth_d = oth_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cut_q <= '0;
      oth_q <= '1;
      bad_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      cut_q <= cut_d;
      oth_q <= oth_d;
      bad_q <= bad_d;
    end
  end

  assign cut_o      = cut_q;
  assign oth_o      = oth_q[AW-1:0];
  assign cut_last_o = (cut_q == hi_q);
  assign oth_more_o = (oth_q <= {1'b0, hi_q});
  assign bad_o      = (lo_i > hi_i);

  // R5
  oth_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oth_more_o |-> (oth_q[AW-1:0] != cut_q));

  // R3
  cut_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_q |-> ((cut_q >= lo_q) && (cut_q <= hi_q)));

endmodule

// File: rtl/tgp_ctrl.sv
module tgp_ctrl
  import tgp_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bad_i,
  input  logic [AW-1:0] cut_i,
  input  logic          cut_last_i,
  input  logic          oth_more_i,
  input  logic          sig_last_i,
  input  logic          sig_match_i,
  input  logic [DW-1:0] rdata_i,
  output logic          walk_start_o,
  output logic          cut_next_o,
  output logic          oth_first_o,
  output logic          oth_next_o,
  output logic          sig_clr_o,
  output logic          sig_load_o,
  output logic          sig_fold_o,
  output logic          sig_save_o,
  output logic          rd_cut_o,
  output logic          rd_oth_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  tgp_state_e    state_q, state_d;
  tgp_pass_e     pass_q, pass_d;
  logic [DW-1:0] orig_q, orig_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] faddr_q, faddr_d;
  logic          inv_pend_q;

  always_comb begin
    state_d      = state_q;
    pass_d       = pass_q;
    orig_d       = orig_q;
    fail_d       = fail_q;
    faddr_d      = faddr_q;
    walk_start_o = 1'b0;
    cut_next_o   = 1'b0;
    oth_first_o  = 1'b0;
    oth_next_o   = 1'b0;
    sig_clr_o    = 1'b0;
    sig_load_o   = 1'b0;
    sig_fold_o   = 1'b0;
    sig_save_o   = 1'b0;
    rd_cut_o     = 1'b0;
    rd_oth_o     = 1'b0;
    wr_o         = 1'b0;
    wdata_o      = orig_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          walk_start_o = 1'b1;
          fail_d       = 1'b0;
          faddr_d      = '0;
          state_d      = bad_i ? ST_FIN : ST_CUT_RD;
        end
      end
      ST_CUT_RD: begin
        rd_cut_o = 1'b1;
        state_d  = ST_CUT_WT;
      end
      ST_CUT_WT: begin
        orig_d      = rdata_i;
        pass_d      = PASS_REF;
        sig_clr_o   = 1'b1;
        oth_first_o = 1'b1;
        state_d     = ST_PASS_CHK;
      end
      ST_PASS_CHK: begin
        state_d = oth_more_i ? ST_SIG_RD : ST_PASS_END;
      end
      ST_SIG_RD: begin
        rd_oth_o = 1'b1;
        state_d  = ST_SIG_WT;
      end
      ST_SIG_WT: begin
        sig_load_o = 1'b1;
        state_d    = ST_FOLD;
      end
      ST_FOLD: begin
        sig_fold_o = 1'b1;
        if (sig_last_i) begin
          if (pass_q == PASS_INV) begin
            state_d = ST_BK_RD;
          end else begin
            oth_next_o = 1'b1;
            state_d    = ST_PASS_CHK;
          end
        end
      end
      ST_BK_RD: begin
        rd_cut_o = 1'b1;
        state_d  = ST_BK_WT;
      end
      ST_BK_WT: begin
        if (rdata_i != ~orig_q) begin
          fail_d  = 1'b1;
          faddr_d = cut_i;
          state_d = ST_RESTORE;
        end else begin
          oth_next_o = 1'b1;
          state_d    = ST_PASS_CHK;
        end
      end
      ST_PASS_END: begin
        unique case (pass_q)
          PASS_REF: begin
            sig_save_o = 1'b1;
            state_d    = ST_INV_WR;
          end
          PASS_INV: begin
            if (!sig_match_i) begin
              fail_d  = 1'b1;
              faddr_d = cut_i;
            end
            state_d = ST_RESTORE;
          end
          default: begin
            if (!sig_match_i) begin
              fail_d  = 1'b1;
              faddr_d = cut_i;
              state_d = ST_FIN;
            end else if (cut_last_i) begin
              state_d = ST_FIN;
            end else begin
              cut_next_o = 1'b1;
              state_d    = ST_CUT_RD;
            end
          end
        endcase
      end
      ST_INV_WR: begin
        wr_o        = 1'b1;
        wdata_o     = ~orig_q;
        pass_d      = PASS_INV;
        sig_clr_o   = 1'b1;
        oth_first_o = 1'b1;
        state_d     = ST_PASS_CHK;
      end
      ST_RESTORE: begin
        wr_o    = 1'b1;
        wdata_o = orig_q;
        if (fail_q) begin
          state_d = ST_FIN;
        end else begin
          pass_d      = PASS_RST;
          sig_clr_o   = 1'b1;
          oth_first_o = 1'b1;
          state_d     = ST_PASS_CHK;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= PASS_REF;
      orig_q  <= '0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      orig_q  <= orig_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  // Checker state: set by the complementing write, cleared by the restoring one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_pend_q <= 1'b0;
    end else if (state_q == ST_INV_WR) begin
      inv_pend_q <= 1'b1;
    end else if (state_q == ST_RESTORE) begin
      inv_pend_q <= 1'b0;
    end
  end

  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign done_o      = (state_q == ST_FIN);
  assign fail_o      = fail_q && !busy_o;
  assign fail_addr_o = faddr_q;

  // R2
  restore_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !inv_pend_q);

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && !$past(busy_o) && !$past(start_i)) |-> $stable(fail_o));

  // R11
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !walk_start_o);

endmodule

// File: rtl/tgp_ram_tester.sv
module tgp_ram_tester #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] lo_addr_i,
  input  logic [AW-1:0] hi_addr_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);
  logic          walk_start, cut_next, oth_first, oth_next;
  logic          sig_clr, sig_load, sig_fold, sig_save, sig_last, sig_match;
  logic          rd_cut, rd_oth, wr;
  logic [AW-1:0] cut, oth;
  logic          cut_last, oth_more, bad;

  tgp_addr_walk #(.AW(AW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (walk_start),
    .lo_i       (lo_addr_i),
    .hi_i       (hi_addr_i),
    .cut_next_i (cut_next),
    .oth_first_i(oth_first),
    .oth_next_i (oth_next),
    .cut_o      (cut),
    .oth_o      (oth),
    .cut_last_o (cut_last),
    .oth_more_o (oth_more),
    .bad_o      (bad)
  );

  tgp_sig_unit #(.DW(DW)) u_sig (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (sig_clr),
    .load_i (sig_load),
    .word_i (mem_rdata_i),
    .fold_i (sig_fold),
    .save_i (sig_save),
    .last_o (sig_last),
    .match_o(sig_match)
  );

  tgp_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bad_i       (bad),
    .cut_i       (cut),
    .cut_last_i  (cut_last),
    .oth_more_i  (oth_more),
    .sig_last_i  (sig_last),
    .sig_match_i (sig_match),
    .rdata_i     (mem_rdata_i),
    .walk_start_o(walk_start),
    .cut_next_o  (cut_next),
    .oth_first_o (oth_first),
    .oth_next_o  (oth_next),
    .sig_clr_o   (sig_clr),
    .sig_load_o  (sig_load),
    .sig_fold_o  (sig_fold),
    .sig_save_o  (sig_save),
    .rd_cut_o    (rd_cut),
    .rd_oth_o    (rd_oth),
    .wr_o        (wr),
    .wdata_o     (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  assign mem_en_o   = rd_cut | rd_oth | wr;
  assign mem_we_o   = wr;
  assign mem_addr_o = rd_oth ? oth : cut;

endmodule

// File: tb/tgp_ram_tester_test.sv
module tgp_ram_tester_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] lo_i = '0, hi_i = '0;
  logic          mem_en_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o, fail_o;
  logic [AW-1:0] fail_addr_o;

  always #2.5 clk = ~clk;

  tgp_ram_tester #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .lo_addr_i(lo_i), .hi_addr_i(hi_i),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o)
  );

  // RAM model with injectable defects: 0 none, 1 write-coupling, 2 stuck bit 0.
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] img [DEPTH];
  int fault_kind = 0, fault_agg = 0, fault_vic = 0;
  int rd_cnt = 0, wr_cnt = 0, oob_cnt = 0, wr_bad = 0, ord_bad = 0;
  int run_lo = 0, run_hi = 0, last_cut = -1;
  bit wr_par = 1'b0;

  always @(posedge clk) begin
    if (rst_n && start_i && !busy_o && !done_o) begin
      run_lo   <= int'(lo_i);
      run_hi   <= int'(hi_i);
      last_cut <= -1;
      wr_par   <= 1'b0;
    end
    if (mem_en_o) begin
      if (int'(mem_addr_o) < run_lo || int'(mem_addr_o) > run_hi) oob_cnt <= oob_cnt + 1;
      if (mem_we_o) begin
        wr_cnt <= wr_cnt + 1;
        wr_par <= ~wr_par;
        if (!wr_par) begin
          if (mem_wdata_o != ~img[mem_addr_o]) wr_bad <= wr_bad + 1;
          if ((last_cut == -1) ? (int'(mem_addr_o) != run_lo) : (int'(mem_addr_o) <= last_cut))
            ord_bad <= ord_bad + 1;
          last_cut <= int'(mem_addr_o);
        end else begin
          if (mem_wdata_o != img[mem_addr_o] || int'(mem_addr_o) != last_cut) wr_bad <= wr_bad + 1;
        end
        if (fault_kind == 2 && int'(mem_addr_o) == fault_agg)
          ram[mem_addr_o] <= {mem_wdata_o[DW-1:1], ram[mem_addr_o][0]};
        else
          ram[mem_addr_o] <= mem_wdata_o;
        if (fault_kind == 1 && int'(mem_addr_o) == fault_agg)
          ram[fault_vic][0] <= ~ram[fault_vic][0];
      end else begin
        rd_cnt      <= rd_cnt + 1;
        mem_rdata_i <= ram[mem_addr_o];
      end
    end
  end

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard: the driver pushes the expected verdict, the monitor pops it at done.
  typedef struct { bit fail; int addr; string req; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errors++;
        $display("FAIL R8 unexpected done: actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (fail_o != e.fail || (e.fail && int'(fail_addr_o) != e.addr)) begin
          mon_errors++;
          $display("FAIL %s verdict: actual=fail%0d@%0d expected=fail%0d@%0d",
                   e.req, fail_o, fail_addr_o, e.fail, e.addr);
        end
      end
    end
  end

  task automatic run_case(input int lo, input int hi, input bit efail, input int eaddr,
                          input int ereads, input int ewrites, input bit poke,
                          input string req);
    int r0, w0, o0, b0, d0, mism;
    exp_t e;
    r0 = rd_cnt; w0 = wr_cnt; o0 = oob_cnt; b0 = wr_bad; d0 = ord_bad;
    e.fail = efail; e.addr = eaddr; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    lo_i = AW'(lo); hi_i = AW'(hi); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (lo > hi) begin
      chk(done_o == 1'b1 && busy_o == 1'b0, "R9", "done next cycle", done_o, 1);
    end else begin
      chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      lo_i = '0; hi_i = '1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R11", "still busy after ignored start", busy_o, 1);
    end
    while (!done_o) @(negedge clk);
    chk(fail_o == efail, req, "fail at done", fail_o, efail);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done single cycle", done_o, 0);
    chk(fail_o == efail, "R8", "fail held after done", fail_o, efail);
    chk(rd_cnt - r0 == ereads, (lo > hi) ? "R9" : "R5", "read count", rd_cnt - r0, ereads);
    chk(wr_cnt - w0 == ewrites, "R4", "write count", wr_cnt - w0, ewrites);
    chk(oob_cnt == o0, "R3", "out-of-window accesses", oob_cnt - o0, 0);
    chk(wr_bad == b0, "R4", "write value/pairing errors", wr_bad - b0, 0);
    chk(ord_bad == d0, "R12", "cell order errors", ord_bad - d0, 0);
    mism = 0;
    for (int i = 0; i < DEPTH; i++) if (ram[i] !== img[i]) mism++;
    chk(mism == 0, "R2", "cells changed by run", mism, 0);
  endtask

  function automatic int clean_reads(input int n);
    return n * (1 + 4 * (n - 1));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = DW'((i * 37 + 11) & 8'hFF);
      ram[i] = img[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !fail_o && !mem_en_o, "R1", "outputs in reset",
        {busy_o, done_o, fail_o, mem_en_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && !mem_en_o, "R1", "outputs after reset",
        {busy_o, done_o, fail_o, mem_en_o}, 0);

    // R5 R12: clean runs of different sizes and positions
    run_case(0, 15, 0, 0, clean_reads(16), 32, 0, "R5");
    run_case(40, 47, 0, 0, clean_reads(8), 16, 0, "R5");
    run_case(60, 63, 0, 0, clean_reads(4), 8, 0, "R12");
    // R10: single cell
    run_case(30, 30, 0, 0, 1, 2, 0, "R10");
    // R9: inverted window
    run_case(10, 5, 0, 0, 0, 0, 0, "R9");

    // R6: coupling defect, writing 5 flips bit 0 of 9; window 2..12 (N=11)
    fault_kind = 1; fault_agg = 5; fault_vic = 9;
    run_case(2, 12, 1, 5, 3 * (1 + 40) + 1 + 30, 8, 0, "R6");
    // R6: victim below aggressor, window 0..5 (N=6)
    fault_agg = 3; fault_vic = 1;
    run_case(0, 5, 1, 3, 3 * (1 + 20) + 1 + 15, 8, 0, "R6");

    // R7: stuck bit 0 at cell 20, window 16..23 (N=8)
    fault_kind = 2; fault_agg = 20;
    run_case(16, 23, 1, 20, 4 * 29 + 8 + 2, 10, 0, "R7");
    fault_kind = 0;

    // R8: fail cleared by the next accepted start
    @(negedge clk);
    chk(fail_o == 1'b1 && int'(fail_addr_o) == 20, "R8", "fail held while idle", fail_addr_o, 20);
    run_case(50, 53, 0, 0, clean_reads(4), 8, 0, "R8");

    // R11: start during a run is ignored
    run_case(0, 7, 0, 0, clean_reads(8), 16, 1, "R11");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "pending scoreboard items", exp_q.size(), 0);
    checks += mon_checks;
    errors += mon_errors;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors += mon_errors + 1;
    checks += mon_checks + 1;
    $display("FAIL R8 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule